// File: doc/BRIEF.md
# Split-Width Add/Subtract Sequencer

The block computes a 32-bit sum or difference on one 16-bit adder, spread over two adder passes. A start pulse latches both operands and an operation select. The first pass combines the lower halves and keeps the carry out of that pass in a register. The second pass combines the upper halves, using that stored carry as its carry-in. The block then shows the full 32-bit result for one cycle, together with a done pulse and the flags of the whole operation.

A subtraction is done as an addition. The second operand is bit-inverted in both passes, and the carry-in of the first pass is set to 1. The carry that passes between the two halves is an internal value only. Both reported flags come from the upper pass. One is the unsigned carry-out of bit 31. The other is the signed overflow, which is the carry into bit 31 XOR the carry out of bit 31.

Top module: `wide_addsub_seq`

## Requirements
- R1: After reset the block is idle: busy_o=0, done_o=0, result_o=0, carry_o=0, ovf_o=0.
- R2: A start_i seen while idle raises busy_o for exactly two cycles, from the first clock edge after the start to the third. done_o is high for one cycle, in the cycle after busy_o falls.
- R3: While done_o=1, result_o holds the low 32 bits of a+b when sub_i=0, and of a+~b+1 when sub_i=1.
- R4: carry_o is the carry out of bit 31. For a subtraction, carry_o=1 means there was no borrow.
- R5: ovf_o is the signed overflow of the 32-bit operation, taken as the carry into bit 31 XOR the carry out of bit 31. A carry between bit 15 and bit 16 never sets it on its own.
- R6: Operands and the op select are latched at start. Changing the inputs or pulsing start_i while busy_o=1 has no effect on the result or on the timing.
- R7: Adding 0x12340100 and 0xFFFFFEFF gives 0x1233FFFF with carry_o=1 and ovf_o=0. Subtracting 0x00000101 from 0x12340100 gives 0x1233FFFF with carry_o=1 (no borrow).
- R8: result_o, carry_o and ovf_o hold their values until the next operation completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, taken only when idle |
| sub_i | input | 1 | 1 = subtract b from a, 0 = add |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| busy_o | output | 1 | High during the low and high passes |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 32 | 32-bit result |
| carry_o | output | 1 | Final carry out of bit 31 |
| ovf_o | output | 1 | Final signed overflow |

## Verification
The hardest case to reach is one where the carry between the halves differs from the final flags. Examples are a low-half carry that then propagates all the way up, and a borrow that stops before reaching the top half. Directed operands cover these cases: all-ones low halves, the 0x7FFF/0x8000 boundaries and the two worked examples. Seeded random operand pairs are mixed in with them. Other runs pulse start and change operands during busy, so that the latching at start can be checked at the result.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_HIGH, ST_DONE} seq_state_e;
endpackage

// File: rtl/half_adder_slice.sv
module half_adder_slice #(
  parameter int W = 16
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         cmsb_o   // carry into the top bit
);
  logic [W-2:0] low_sum;
  logic         msb_sum;
  always_comb begin
    {cmsb_o, low_sum} = {1'b0, x_i[W-2:0]} + {1'b0, y_i[W-2:0]} + {{(W-1){1'b0}}, cin_i};
    {cout_o, msb_sum} = {1'b0, x_i[W-1]} + {1'b0, y_i[W-1]} + {1'b0, cmsb_o};
    sum_o = {msb_sum, low_sum};
  end
endmodule

// File: rtl/wide_addsub_seq.sv
module wide_addsub_seq #(
  parameter int WIDTH = 32,
  parameter int SLICE = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             sub_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] result_o,
  output logic             carry_o,
  output logic             ovf_o
);
  import addsub_pkg::*;
  localparam int HW = WIDTH - SLICE;

  seq_state_e        state_q;
  logic [WIDTH-1:0]  a_q, b_q;
  logic              sub_q, mid_c_q;
  logic [SLICE-1:0]  lo_q;
  logic [SLICE-1:0]  x, y, s;
  logic              cin, cout, cmsb;

  // one shared adder; operand b inverted for subtraction
  always_comb begin
    if (state_q == ST_HIGH) begin
      x   = a_q[WIDTH-1 -: SLICE];
      y   = b_q[WIDTH-1 -: SLICE] ^ {SLICE{sub_q}};
      cin = mid_c_q;
    end else begin
      x   = a_q[SLICE-1:0];
      y   = b_q[SLICE-1:0] ^ {SLICE{sub_q}};
      cin = sub_q;
    end
  end

  half_adder_slice #(.W(SLICE)) u_add (
    .x_i(x), .y_i(y), .cin_i(cin), .sum_o(s), .cout_o(cout), .cmsb_o(cmsb)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      a_q      <= '0;
      b_q      <= '0;
      sub_q    <= 1'b0;
      mid_c_q  <= 1'b0;
      lo_q     <= '0;
      result_o <= '0;
      carry_o  <= 1'b0;
      ovf_o    <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          a_q     <= a_i;
          b_q     <= b_i;
          sub_q   <= sub_i;
          state_q <= ST_LOW;
        end
        ST_LOW: begin
          lo_q    <= s;
          mid_c_q <= cout;
          state_q <= ST_HIGH;
        end
        ST_HIGH: begin
          result_o <= {s[HW-1:0], lo_q};
          carry_o  <= cout;
          ovf_o    <= cout ^ cmsb;
          state_q  <= ST_DONE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q == ST_LOW) || (state_q == ST_HIGH);
  assign done_o = (state_q == ST_DONE);

  assert_busy_len_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |=> busy_o);
  assert_done_after_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  assert_done_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_exclusive_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));
  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_o && !$rose(done_o)) |-> $stable(result_o));
  assert_ops_latched_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(a_q) && $stable(b_q) && $stable(sub_q));
endmodule

// File: tb/tb_wide_addsub_seq.sv
module tb_wide_addsub_seq;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, rst_n = 0, start = 0, sub = 0;
  logic [31:0] a = 0, b = 0;
  logic busy, done, c, v;
  logic [31:0] res;
  int checks = 0, fails = 0;

  wide_addsub_seq dut (.clk_i(clk), .rst_ni(rst_n), .start_i(start), .sub_i(sub),
    .a_i(a), .b_i(b), .busy_o(busy), .done_o(done), .result_o(res), .carry_o(c), .ovf_o(v));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [33:0] model(input logic [31:0] x, y, input logic s);
    logic [32:0] full;
    logic [31:0] yy;
    logic cin31;
    yy = s ? ~y : y;
    full = {1'b0, x} + {1'b0, yy} + {32'd0, s};
    cin31 = full[31] ^ x[31] ^ yy[31];
    return {full[32], full[32] ^ cin31, full[31:0]};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // negedge-driven op; checks timing, result and flags
  task automatic run(input logic [31:0] x, y, input logic s, input bit disturb, input string req);
    logic [33:0] e;
    e = model(x, y, s);
    @(negedge clk); a = x; b = y; sub = s; start = 1;
    @(negedge clk); start = disturb;
    if (disturb) begin a = ~x; b = x ^ y; sub = ~s; end
    chk({"R2 busy1 ", req}, {62'd0, busy, done}, 64'd2);
    @(negedge clk);
    chk({"R2 busy2 ", req}, {62'd0, busy, done}, 64'd2);
    @(negedge clk); start = 0;
    chk({"R2 done ", req}, {62'd0, busy, done}, 64'd1);
    chk({"R3 result ", req}, {32'd0, res}, {32'd0, e[31:0]});
    chk({"R4 carry ", req}, {63'd0, c}, {63'd0, e[33]});
    chk({"R5 ovf ", req}, {63'd0, v}, {63'd0, e[32]});
    @(negedge clk);
    chk({"R8 hold ", req}, {29'd0, done, c, v, res}, {30'd0, e[33], e[32], e[31:0]});
    start = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    fails++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #(CLK_PERIOD*2 + 1);
    chk("R1 reset", {29'd0, busy, done, c, v, res}, 64'd0);
    rst_n = 1;
    run(32'h12340100, 32'hFFFFFEFF, 0, 0, "R7 add");
    chk("R7 add value", {32'd0, res}, 64'h1233FFFF);
    run(32'h12340100, 32'h00000101, 1, 0, "R7 sub");
    chk("R7 sub carry", {63'd0, c}, 64'd1);
    run(32'h0000FFFF, 32'h00000001, 0, 0, "R5 midcarry");
    chk("R5 no ovf from mid carry", {63'd0, v}, 64'd0);
    run(32'h7FFFFFFF, 32'h00000001, 0, 0, "R5 posovf");
    run(32'h80000000, 32'h00000001, 1, 0, "R5 negovf");
    run(32'h00000000, 32'h00000001, 1, 0, "R4 borrow");
    run(32'hFFFFFFFF, 32'hFFFFFFFF, 0, 0, "R4 allones");
    run(32'h80000000, 32'h80000000, 0, 0, "R5 minmin");
    run(32'h00010000, 32'h00000001, 1, 0, "R4 midborrow");
    run(32'h5A5A1234, 32'h0F0F4321, 0, 1, "R6 disturb add");
    run(32'h00000000, 32'hFFFFFFFF, 1, 1, "R6 disturb sub");
    for (int i = 0; i < 200; i++)
      run($urandom, $urandom, 1'($urandom), 1'($urandom), "R3 random");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule